// File: doc/BRIEF.md
# Descriptor-Driven NAND Data Mover

This block moves a NAND data phase between system memory and the NAND byte stream. It does not take an address and length from registers. Software builds a four-word descriptor in memory and hands it over by setting the descriptor's ownership bit. Software then pulses `start_i` and supplies three things: the descriptor base address, the direction, and the number of bytes the NAND operation carries.

The engine fetches the descriptor as two 64-bit beats and refuses it if the ownership bit is clear. Otherwise it moves up to two buffers in 8-byte beats, least significant byte lane first:

- **Transmit:** it feeds bytes to the NAND sequencer.
- **Receive:** it gathers bytes from the sequencer and writes them to memory.

Afterwards it writes the descriptor's first beat back with ownership cleared. It then pulses a completion flag for the direction it ran.

Memory is reached through a request/grant port with one transaction in flight. Read data returns on a separate valid strobe.

Top module: `nand_desc_dma`

## Requirements
- R1: On an accepted start the engine reads the beat at the base address and then the beat at base+8. In the first beat, bits [31:0] are the status word and bits [63:32] the sizes word. In the second beat, bits [31:0] are buffer pointer 0 and bits [63:32] are buffer pointer 1.
- R2: If status bit 31 (ownership) is clear, `desc_unavail_o` pulses. No buffer is read or written, no stream handshake happens, and the descriptor is not written back.
- R3: In transmit (`dir_i`=0) the buffers' bytes are emitted in rising address order. Only the first `nand_len_i` bytes of the combined buffers appear on the stream. The remaining bytes of the last beat are read but dropped.
- R4: In receive (`dir_i`=1) the engine accepts `nand_len_i` bytes and writes them to the buffers in rising address order. Every byte position past `nand_len_i`, up to the end of the buffer space, is written as zero.
- R5: Buffer 0 length is sizes[11:0] and buffer 1 length is sizes[23:12], both in bytes. Bits [2:0] of each length are ignored. A buffer whose length is under 8 bytes is skipped.
- R6: Buffer 1 is used only when pointer 1 is non-zero.
- R7: After the transfer, the engine writes back to the base address the first descriptor beat, with status bit 31 cleared and every other bit unchanged.
- R8: Exactly one of `tx_done_o`, `rx_done_o` and `desc_unavail_o` pulses for one cycle at the end of each run, matching the direction. `busy_o` drops on the following cycle. All three flags and `busy_o` are low after reset.
- R9: Once `mem_req_o` rises, it stays high with the same address, write enable and write data until `mem_gnt_i`.
- R10: `tx_valid_o` holds with unchanged `tx_data_o` until `tx_ready_i`. `rx_ready_o` is high only while received bytes are still owed. With `busy_o` low, no request or stream strobe is active.
- R11: A start pulse while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (ignored while busy) |
| dir_i | input | 1 | 0 transmit to NAND, 1 receive from NAND |
| nand_len_i | input | 13 | Bytes carried by the NAND data phase |
| desc_base_i | input | 32 | Descriptor base byte address, 8-byte aligned |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Beat byte address |
| mem_wdata_o | output | 64 | Write beat |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read beat valid |
| mem_rdata_i | input | 64 | Read beat |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Sequencer takes the byte |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Engine takes the byte |
| busy_o | output | 1 | Run in progress |
| tx_done_o | output | 1 | Transmit run complete pulse |
| rx_done_o | output | 1 | Receive run complete pulse |
| desc_unavail_o | output | 1 | Descriptor not owned pulse |

## Verification
The checker watches the handshake rules on every cycle:

- memory requests and transmit bytes hold until accepted;
- at most one end flag is raised, and `busy_o` falls right after it;
- nothing strobes while idle;
- every write to the descriptor address carries a cleared ownership bit.

Other behaviour only the scenarios can show. These cover the byte order across two buffers, truncation to the NAND length, zero padding of received data, skipping of short or absent buffers, refusal of a descriptor that is not owned, and the ignoring of a second start. The scenarios compare streamed bytes and final memory contents against values derived from the descriptor. Grant and ready stalls come from a pseudo-random pattern throughout.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int WORD_W     = 32;
  localparam int BEAT_BYTES = 8;
  localparam int DATA_W     = BEAT_BYTES * 8;
  localparam int LANE_W     = $clog2(BEAT_BYTES);
  localparam int OWN_BIT    = 31;

  typedef enum logic [3:0] {
    S_IDLE, S_D0_REQ, S_D0_WAIT, S_D1_REQ, S_D1_WAIT, S_BUF_SEL,
    S_RD_REQ, S_RD_WAIT, S_TX_SHIFT, S_RX_FILL, S_WR_REQ, S_WB, S_DONE
  } dma_state_e;
endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ld_lo_i,
  input  logic                    ld_hi_i,
  input  logic [DATA_W-1:0]       beat_i,
  output logic [LEN_W-LANE_W-1:0] beats0_o,
  output logic [LEN_W-LANE_W-1:0] beats1_o,
  output logic [WORD_W-1:0]       ptr0_o,
  output logic [WORD_W-1:0]       ptr1_o,
  output logic [DATA_W-1:0]       wb_beat_o
);
  logic [WORD_W-1:0] status_q, sizes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      sizes_q  <= '0;
      ptr0_o   <= '0;
      ptr1_o   <= '0;
    end else begin
      if (ld_lo_i) begin
        status_q <= beat_i[WORD_W-1:0];
        sizes_q  <= beat_i[DATA_W-1:WORD_W];
      end
      if (ld_hi_i) begin
        ptr0_o <= beat_i[WORD_W-1:0];
        ptr1_o <= beat_i[DATA_W-1:WORD_W];
      end
    end
  end

  // length fields floored to whole beats
  assign beats0_o  = sizes_q[LEN_W-1:LANE_W];
  assign beats1_o  = sizes_q[2*LEN_W-1:LEN_W+LANE_W];
  assign wb_beat_o = {sizes_q, status_q & ~(WORD_W'(1) << OWN_BIT)};
endmodule

// File: rtl/dma_lane_buf.sv
module dma_lane_buf
  import dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] beat_i,
  input  logic              put_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [7:0]        byte_i,
  output logic [DATA_W-1:0] beat_o,
  output logic [7:0]        byte_o
);
  for (genvar g = 0; g < BEAT_BYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              beat_o[g*8 +: 8] <= '0;
      else if (load_i)                          beat_o[g*8 +: 8] <= beat_i[g*8 +: 8];
      else if (put_i && lane_i == LANE_W'(g))   beat_o[g*8 +: 8] <= byte_i;
    end
  end

  assign byte_o = beat_o[8*lane_i +: 8];
endmodule

// File: rtl/nand_desc_dma.sv
module nand_desc_dma
  import dma_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [LEN_W:0]    nand_len_i,
  input  logic [WORD_W-1:0] desc_base_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              busy_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic              desc_unavail_o
);
  localparam int BEAT_W = LEN_W - LANE_W;
  localparam int CNT_W  = LEN_W + 1;
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(BEAT_BYTES - 1);

  dma_state_e        state_q;
  logic              dir_q, ok_q, buf_q;
  logic [CNT_W-1:0]  nlen_q, byte_q;
  logic [WORD_W-1:0] base_q, addr_q;
  logic [BEAT_W-1:0] beats_q;
  logic [LANE_W-1:0] lane_q;

  logic [BEAT_W-1:0] beats0, beats1, sel_beats;
  logic [WORD_W-1:0] ptr0, ptr1, sel_ptr;
  logic [DATA_W-1:0] wb_beat, lane_beat;
  logic [7:0]        lane_byte;
  logic              wants, adv, ld_lo, ld_hi, tx_load, rx_put;

  assign ld_lo   = state_q == S_D0_WAIT && mem_rvalid_i;
  assign ld_hi   = state_q == S_D1_WAIT && mem_rvalid_i;
  assign tx_load = state_q == S_RD_WAIT && mem_rvalid_i;

  dma_desc_regs #(.LEN_W(LEN_W)) u_desc (
    .clk_i, .rst_ni,
    .ld_lo_i(ld_lo), .ld_hi_i(ld_hi), .beat_i(mem_rdata_i),
    .beats0_o(beats0), .beats1_o(beats1),
    .ptr0_o(ptr0), .ptr1_o(ptr1), .wb_beat_o(wb_beat)
  );

  assign wants = byte_q < nlen_q;
  assign adv   = (state_q == S_TX_SHIFT && (!wants || tx_ready_i)) ||
                 (state_q == S_RX_FILL  && (!wants || rx_valid_i));
  assign rx_put = state_q == S_RX_FILL && adv;

  dma_lane_buf u_lane (
    .clk_i, .rst_ni,
    .load_i(tx_load), .beat_i(mem_rdata_i),
    .put_i(rx_put), .lane_i(lane_q),
    .byte_i(wants ? rx_data_i : 8'h00),
    .beat_o(lane_beat), .byte_o(lane_byte)
  );

  // buffer 1 exists only with a non-zero pointer
  assign sel_ptr   = buf_q ? ptr1 : ptr0;
  assign sel_beats = buf_q ? ((ptr1 != '0) ? beats1 : '0) : beats0;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_q;
    mem_wdata_o = lane_beat;
    unique case (state_q)
      S_D0_REQ: begin mem_req_o = 1'b1; mem_addr_o = base_q; end
      S_D1_REQ: begin mem_req_o = 1'b1; mem_addr_o = base_q + WORD_W'(BEAT_BYTES); end
      S_RD_REQ: mem_req_o = 1'b1;
      S_WR_REQ: begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = base_q;
        mem_wdata_o = wb_beat;
      end
      default: ;
    endcase
  end

  assign tx_valid_o     = state_q == S_TX_SHIFT && wants;
  assign tx_data_o      = lane_byte;
  assign rx_ready_o     = state_q == S_RX_FILL && wants;
  assign busy_o         = state_q != S_IDLE;
  assign tx_done_o      = state_q == S_DONE && ok_q && !dir_q;
  assign rx_done_o      = state_q == S_DONE && ok_q && dir_q;
  assign desc_unavail_o = state_q == S_DONE && !ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      dir_q   <= 1'b0;
      ok_q    <= 1'b0;
      buf_q   <= 1'b0;
      nlen_q  <= '0;
      byte_q  <= '0;
      base_q  <= '0;
      addr_q  <= '0;
      beats_q <= '0;
      lane_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          base_q  <= desc_base_i;
          dir_q   <= dir_i;
          nlen_q  <= nand_len_i;
          state_q <= S_D0_REQ;
        end
        S_D0_REQ:  if (mem_gnt_i) state_q <= S_D0_WAIT;
        S_D0_WAIT: if (mem_rvalid_i) begin
          ok_q    <= mem_rdata_i[OWN_BIT];
          state_q <= mem_rdata_i[OWN_BIT] ? S_D1_REQ : S_DONE;
        end
        S_D1_REQ:  if (mem_gnt_i) state_q <= S_D1_WAIT;
        S_D1_WAIT: if (mem_rvalid_i) begin
          buf_q   <= 1'b0;
          byte_q  <= '0;
          state_q <= S_BUF_SEL;
        end
        S_BUF_SEL: begin
          if (sel_beats != '0) begin
            addr_q  <= sel_ptr;
            beats_q <= sel_beats;
            lane_q  <= '0;
            state_q <= dir_q ? S_RX_FILL : S_RD_REQ;
          end else if (buf_q) begin
            state_q <= S_WB;
          end else begin
            buf_q <= 1'b1;
          end
        end
        S_RD_REQ:  if (mem_gnt_i) state_q <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rvalid_i) state_q <= S_TX_SHIFT;
        S_TX_SHIFT, S_RX_FILL: if (adv) begin
          lane_q <= lane_q + 1'b1;
          byte_q <= byte_q + 1'b1;
          if (lane_q == LANE_LAST) begin
            if (dir_q) state_q <= S_WR_REQ;
            else       state_q <= (beats_q == BEAT_W'(1)) ? S_BUF_SEL : S_RD_REQ;
            if (!dir_q) begin
              beats_q <= beats_q - 1'b1;
              addr_q  <= addr_q + WORD_W'(BEAT_BYTES);
              if (beats_q == BEAT_W'(1)) begin
                if (buf_q) state_q <= S_WB;
                else       buf_q   <= 1'b1;
              end
            end
          end
        end
        S_WR_REQ: if (mem_gnt_i) begin
          beats_q <= beats_q - 1'b1;
          addr_q  <= addr_q + WORD_W'(BEAT_BYTES);
          if (beats_q == BEAT_W'(1)) begin
            if (buf_q) state_q <= S_WB;
            else begin
              buf_q   <= 1'b1;
              state_q <= S_BUF_SEL;
            end
          end else begin
            state_q <= S_RX_FILL;
          end
        end
        S_WB:    if (mem_gnt_i) state_q <= S_DONE;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_desc_dma_chk.sv
module nand_desc_dma_chk
  import dma_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [WORD_W-1:0] desc_base_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [WORD_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_gnt_i,
  input logic              tx_valid_o,
  input logic [7:0]        tx_data_o,
  input logic              tx_ready_i,
  input logic              rx_ready_o,
  input logic              busy_o,
  input logic              tx_done_o,
  input logic              rx_done_o,
  input logic              desc_unavail_o
);
  logic [WORD_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                base_q <= '0;
    else if (start_i && !busy_o) base_q <= desc_base_i;
  end

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_tx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tx_valid_o && !rx_ready_o && !mem_req_o);

  assert_one_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_done_o, rx_done_o, desc_unavail_o}));

  assert_flag_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_o || rx_done_o || desc_unavail_o) |=> !busy_o);

  assert_wb_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_addr_o == base_q |-> !mem_wdata_o[OWN_BIT]);
endmodule

bind nand_desc_dma nand_desc_dma_chk u_chk (.*);

// File: tb/nand_desc_dma_tb.sv
module nand_desc_dma_tb;
  import dma_pkg::*;
  localparam int LEN_W = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, start, dir;
  logic [LEN_W:0]    nand_len;
  logic [31:0]       desc_base;
  logic              mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0]       mem_addr;
  logic [63:0]       mem_wdata, mem_rdata;
  logic              tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0]        tx_data, rx_data;
  logic              busy, tx_done, rx_done, unavail;

  nand_desc_dma #(.LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_i(dir),
    .nand_len_i(nand_len), .desc_base_i(desc_base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_ready_i(tx_ready), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_ready_o(rx_ready), .busy_o(busy), .tx_done_o(tx_done),
    .rx_done_o(rx_done), .desc_unavail_o(unavail)
  );

  logic [63:0] mem [0:63];
  logic [7:0]  exp_q[$];
  int          checks = 0, errors = 0, cyc = 0;
  int          txd_n = 0, rxd_n = 0, una_n = 0;
  logic [7:0]  lfsr = 8'h5a, rx_pat = 8'hA0;
  logic        rd_pend = 1'b0;
  logic [5:0]  rd_idx = '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model, stream partners and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (!rst_n) begin
      mem_gnt = 0; mem_rvalid = 0; tx_ready = 0; rx_valid = 0; rx_data = 0;
    end else begin
      mem_rvalid = rd_pend;
      if (rd_pend) mem_rdata = mem[rd_idx];
      rd_pend = 0;
      mem_gnt = mem_req && (lfsr[1:0] != 2'b00);
      if (mem_gnt) begin
        if (mem_we) mem[mem_addr[8:3]] = mem_wdata;
        else begin rd_pend = 1; rd_idx = mem_addr[8:3]; end
      end
      tx_ready = lfsr[2] | lfsr[6];
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) check(0, "R3 surplus tx byte", {56'd0, tx_data}, 64'd0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(tx_data == e, "R3/R10 tx byte", {56'd0, tx_data}, {56'd0, e});
        end
      end
      rx_valid = lfsr[3] | lfsr[7];
      rx_data  = rx_pat;
      if (rx_ready && rx_valid) rx_pat = rx_pat + 8'd1;
      if (tx_done) txd_n++;
      if (rx_done) rxd_n++;
      if (unavail) una_n++;
    end
  end

  task automatic set_desc(input int base, input logic [31:0] st, input logic [31:0] sz,
                          input logic [31:0] p0, input logic [31:0] p1);
    mem[base >> 3]       = {sz, st};
    mem[(base >> 3) + 1] = {p1, p0};
  endtask

  task automatic set_byte(input int a, input logic [7:0] v);
    mem[a >> 3][(a & 7) * 8 +: 8] = v;
  endtask

  function automatic logic [7:0] get_byte(input int a);
    return mem[a >> 3][(a & 7) * 8 +: 8];
  endfunction

  // driver side of the scoreboard: expected transmit bytes
  task automatic push_tx(input int a, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(get_byte(a + i));
  endtask

  task automatic run(input logic d, input int nlen, input bit poke);
    @(negedge clk);
    start = 1; dir = d; nand_len = (LEN_W+1)'(nlen); desc_base = 32'h0;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1; dir = ~d;
      @(negedge clk);
      start = 0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  int t0, r0, u0;
  logic [7:0] pat0;
  logic [63:0] snap0, snapb;

  initial begin
    rst_n = 0; start = 0; dir = 0; nand_len = '0; desc_base = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !tx_done && !rx_done && !unavail, "R8 reset flags",
          {60'd0, busy, tx_done, rx_done, unavail}, 64'd0);
    check(!mem_req && !tx_valid && !rx_ready, "R10 reset strobes",
          {61'd0, mem_req, tx_valid, rx_ready}, 64'd0);

    // transmit, one buffer, full length
    set_desc(0, 32'h8000_000C, 32'd16, 32'h40, 32'h0);
    for (int i = 0; i < 16; i++) set_byte('h40 + i, 8'h10 + 8'(i));
    push_tx('h40, 16);
    t0 = txd_n; r0 = rxd_n;
    run(0, 16, 0);
    check(exp_q.size() == 0, "R3/R9 all tx bytes seen", 64'(exp_q.size()), 64'd0);
    check(txd_n - t0 == 1 && rxd_n == r0, "R8 tx_done once", 64'(txd_n - t0), 64'd1);
    check(mem[0] == {32'd16, 32'h0000_000C}, "R1/R7 write-back", mem[0], {32'd16, 32'h0000_000C});
    exp_q.delete();

    // transmit truncated to the NAND length
    set_desc(0, 32'h8000_000C, 32'd16, 32'h40, 32'h0);
    push_tx('h40, 11);
    run(0, 11, 0);
    check(exp_q.size() == 0, "R3 truncated tx", 64'(exp_q.size()), 64'd0);
    exp_q.delete();

    // receive with zero padding
    set_desc(0, 32'h8000_000C, 32'd24, 32'h100, 32'h0);
    for (int i = 0; i < 3; i++) mem[('h100 >> 3) + i] = '1;
    pat0 = rx_pat; r0 = rxd_n;
    run(1, 19, 0);
    for (int i = 0; i < 24; i++)
      check(get_byte('h100 + i) == ((i < 19) ? pat0 + 8'(i) : 8'h00), "R4 rx byte",
            {56'd0, get_byte('h100 + i)}, {56'd0, (i < 19) ? pat0 + 8'(i) : 8'h00});
    check(rxd_n - r0 == 1, "R8 rx_done once", 64'(rxd_n - r0), 64'd1);
    check(mem[0][31] == 1'b0, "R7 rx write-back ownership", {63'd0, mem[0][31]}, 64'd0);

    // transmit across two buffers
    set_desc(0, 32'h8000_000C, 32'h0001_0008, 32'h40, 32'h180);
    for (int i = 0; i < 16; i++) set_byte('h180 + i, 8'h60 + 8'(i));
    push_tx('h40, 8);
    push_tx('h180, 16);
    run(0, 24, 0);
    check(exp_q.size() == 0, "R5/R6 two-buffer tx", 64'(exp_q.size()), 64'd0);
    exp_q.delete();

    // second length present but pointer zero: buffer 1 unused
    set_desc(0, 32'h8000_000C, 32'h0001_0008, 32'h40, 32'h0);
    push_tx('h40, 8);
    t0 = txd_n;
    run(0, 24, 0);
    check(exp_q.size() == 0 && txd_n - t0 == 1, "R6 null pointer skips buffer 1",
          64'(exp_q.size()), 64'd0);
    exp_q.delete();

    // low length bits ignored
    set_desc(0, 32'h8000_000C, 32'd13, 32'h40, 32'h0);
    push_tx('h40, 8);
    run(0, 13, 0);
    check(exp_q.size() == 0, "R5 length floored to beats", 64'(exp_q.size()), 64'd0);
    exp_q.delete();

    // descriptor not owned
    set_desc(0, 32'h0000_000C, 32'd16, 32'h100, 32'h0);
    mem['h100 >> 3] = 64'hCAFE_F00D_1234_5678;
    snap0 = mem[0]; snapb = mem['h100 >> 3];
    u0 = una_n; t0 = txd_n; r0 = rxd_n; pat0 = rx_pat;
    run(1, 16, 0);
    check(una_n - u0 == 1 && txd_n == t0 && rxd_n == r0, "R2 unavailable flag",
          64'(una_n - u0), 64'd1);
    check(mem[0] == snap0, "R2 no write-back", mem[0], snap0);
    check(mem['h100 >> 3] == snapb && rx_pat == pat0, "R2 no transfer", mem['h100 >> 3], snapb);

    // start while busy is ignored
    set_desc(0, 32'h8000_000C, 32'd16, 32'h100, 32'h0);
    pat0 = rx_pat; t0 = txd_n; r0 = rxd_n;
    run(1, 16, 1);
    check(rxd_n - r0 == 1 && txd_n == t0, "R11 one run only", 64'(rxd_n - r0), 64'd1);
    check(get_byte('h10F) == pat0 + 8'd15, "R11 data intact", {56'd0, get_byte('h10F)},
          {56'd0, pat0 + 8'd15});

    // empty buffer 0, receive into buffer 1
    set_desc(0, 32'h8000_000C, 32'h0000_8000, 32'h100, 32'h180);
    pat0 = rx_pat;
    run(1, 8, 0);
    for (int i = 0; i < 8; i++)
      check(get_byte('h180 + i) == pat0 + 8'(i), "R5 zero-length buffer 0 skipped",
            {56'd0, get_byte('h180 + i)}, {56'd0, pat0 + 8'(i)});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule